// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is the target end of a three-wire serial link made of an active-low select, a bus clock and one bidirectional data line. Every frame opens with a 9-bit header that names a device, gives a transfer direction and picks a register. A 16-bit data phase follows. On a write the slave collects the data and then issues one write strobe. On a read it fetches the register right after the header and shifts the value back out on the data line, enabling its output driver for that phase only.

All three bus inputs are sampled in the system clock domain through two-flop synchronizers. Bus clock edges are found there too, so the bus clock has to run well below the system clock; each bus level must last at least four system cycles. One instance can answer any subset of the eight device addresses, given by a mask parameter. The attached register file sees a plain parallel port: device, register number, read and write strobes, write data, and a read data input that the file returns combinationally.

Top module: `tw_reg_slave`

## Requirements
- R1: While reset is held and right after it, `bus_dat_oe_o`, `reg_rd_o` and `reg_wr_o` are all 0.
- R2: The slave acts only on a rising edge of `bus_clk_i` seen while `bus_sel_n_i` is low. Clock edges given while select is high change nothing.
- R3: While `bus_sel_n_i` is high the slave returns to header reception. It drops any partly received frame and disables its output.
- R4: Header bits arrive most-significant first, 9 bits in all. Bits [8:6] are the device address, bit [5] is the direction (1 = read, 0 = write) and bits [4:0] are the register number.
- R5: On a write, the 16 data bits arrive most-significant first. After the last bit, `reg_wr_o` pulses for exactly one system cycle, with `reg_dev_o`, `reg_addr_o` and `reg_wdata_o` holding the header fields and the data.
- R6: On a read, `reg_rd_o` pulses for one system cycle after the ninth header bit, and `reg_rdata_i` is taken in that cycle. Each of the next 16 rising bus edges then drives one bit onto `bus_dat_o`, most-significant first.
- R7: `bus_dat_oe_o` rises when the header of a matching read completes. It stays high through the data phase and falls on the next rising bus edge in the header phase, or when select goes high.
- R8: A device address whose bit in `DEV_MASK` is 0 (the default mask 0x06 answers addresses 1 and 2) produces no strobe, and the output stays disabled.
- R9: After 16 data bits the slave is back in header reception, so frames can follow one another without select being released.
- R10: `reg_rd_o` and `reg_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n_i | input | 1 | Bus select, active low |
| bus_clk_i | input | 1 | Bus clock |
| bus_dat_i | input | 1 | Data line as seen at the pin |
| bus_dat_o | output | 1 | Data value driven during a read |
| bus_dat_oe_o | output | 1 | Output enable for the data line |
| reg_dev_o | output | DEV_W | Device address of the current transfer |
| reg_addr_o | output | REG_W | Register number of the current transfer |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data, valid with `reg_wr_o` |
| reg_rdata_i | input | DATA_W | Read data, taken in the `reg_rd_o` cycle |

## Verification
Some properties are checked on every cycle by the assertions. The strobes must never overlap and each lasts a single cycle. The output enable and the write strobe may only appear for a matching transfer in the right direction. A high select must leave the slave in header reception with its driver off. The bench scenarios cover what needs a whole frame to show. They check that bits land in the right header fields and data positions, in both directions, through a register model the bench keeps. They check that a frame aborted mid-header or mid-data leaves no trace, that clock edges given while deselected are ignored, and that the driver keeps the last read bit until select rises.

// File: rtl/tws_pkg.sv
package tws_pkg;
  // Frame phase: header reception or data transfer
  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tws_decode.sv
module tws_decode #(
  parameter int                      DEV_W    = 3,
  parameter int                      REG_W    = 5,
  parameter logic [(2**DEV_W)-1:0]   DEV_MASK = 'h06,
  localparam int                     HDR_W    = DEV_W + 1 + REG_W,
  localparam int                     NUM_DEV  = 2**DEV_W
) (
  input  logic [HDR_W-1:0] hdr_i,
  output logic [DEV_W-1:0] dev_o,
  output logic             rd_o,
  output logic [REG_W-1:0] reg_o,
  output logic             hit_o
);
  logic [NUM_DEV-1:0] hit_vec;

  assign dev_o = hdr_i[HDR_W-1 -: DEV_W];
  assign rd_o  = hdr_i[REG_W];
  assign reg_o = hdr_i[REG_W-1:0];

  // one comparator per possible device, kept only where the mask enables it
  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    if (DEV_MASK[i]) begin : g_on
      assign hit_vec[i] = (dev_o == DEV_W'(i));
    end else begin : g_off
      assign hit_vec[i] = 1'b0;
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/tws_link.sv
module tws_link
  import tws_pkg::*;
#(
  parameter int                    DEV_W    = 3,
  parameter int                    REG_W    = 5,
  parameter int                    DATA_W   = 16,
  parameter logic [(2**DEV_W)-1:0] DEV_MASK = 'h06,
  localparam int                   HDR_W    = DEV_W + 1 + REG_W,
  localparam int                   MAX_W    = (HDR_W > DATA_W) ? HDR_W : DATA_W,
  localparam int                   CNT_W    = $clog2(MAX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              bclk_s,
  input  logic              dat_s,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DEV_W-1:0]  reg_dev_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              dat_o,
  output logic              dat_oe_o
);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  phase_e              phase_q, phase_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [DATA_W-1:0]   sh_q, sh_n;
  logic [DEV_W-1:0]    dev_q, dev_n;
  logic [REG_W-1:0]    reg_q, reg_n;
  logic                rw_q, rw_n;
  logic                hit_q, hit_n;
  logic                oe_q, oe_n;
  logic                dout_q, dout_n;
  logic                rd_q, rd_n;
  logic                wr_q, wr_n;
  logic                bclk_q;
  logic                rise;

  logic [HDR_W-1:0]    hdr_word;
  logic [DEV_W-1:0]    d_dev;
  logic [REG_W-1:0]    d_reg;
  logic                d_rw;
  logic                d_hit;

  assign rise     = bclk_s & ~bclk_q;
  assign hdr_word = {sh_q[HDR_W-2:0], dat_s};

  tws_decode #(
    .DEV_W    (DEV_W),
    .REG_W    (REG_W),
    .DEV_MASK (DEV_MASK)
  ) u_decode (
    .hdr_i (hdr_word),
    .dev_o (d_dev),
    .rd_o  (d_rw),
    .reg_o (d_reg),
    .hit_o (d_hit)
  );

  // next-state logic
  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    dev_n   = dev_q;
    reg_n   = reg_q;
    rw_n    = rw_q;
    hit_n   = hit_q;
    oe_n    = oe_q;
    dout_n  = dout_q;
    rd_n    = 1'b0;
    wr_n    = 1'b0;
    if (sel_s) begin
      phase_n = PH_HDR;
      cnt_n   = '0;
      sh_n    = '0;
      oe_n    = 1'b0;
    end else begin
      if (rd_q) sh_n = reg_rdata_i;
      if (rise) begin
        unique case (phase_q)
          PH_HDR: begin
            oe_n = 1'b0;
            sh_n = {sh_q[DATA_W-2:0], dat_s};
            if (cnt_q == HDR_LAST) begin
              phase_n = PH_DATA;
              cnt_n   = '0;
              sh_n    = '0;
              dev_n   = d_dev;
              reg_n   = d_reg;
              rw_n    = d_rw;
              hit_n   = d_hit;
              rd_n    = d_hit & d_rw;
              oe_n    = d_hit & d_rw;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (rw_q) begin
              dout_n = sh_q[DATA_W-1];
              sh_n   = {sh_q[DATA_W-2:0], 1'b0};
            end else begin
              sh_n   = {sh_q[DATA_W-2:0], dat_s};
            end
            if (cnt_q == DATA_LAST) begin
              phase_n = PH_HDR;
              cnt_n   = '0;
              wr_n    = hit_q & ~rw_q;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
          default: phase_n = PH_HDR;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      dev_q   <= '0;
      reg_q   <= '0;
      rw_q    <= 1'b0;
      hit_q   <= 1'b0;
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      bclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      dev_q   <= dev_n;
      reg_q   <= reg_n;
      rw_q    <= rw_n;
      hit_q   <= hit_n;
      oe_q    <= oe_n;
      dout_q  <= dout_n;
      rd_q    <= rd_n;
      wr_q    <= wr_n;
      bclk_q  <= bclk_s;
    end
  end

  assign reg_dev_o   = dev_q;
  assign reg_addr_o  = reg_q;
  assign reg_rd_o    = rd_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = sh_q;
  assign dat_o       = dout_q;
  assign dat_oe_o    = oe_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R8
  oe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (hit_q && rw_q));

  // R5
  wr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (hit_q && !rw_q && phase_q == PH_HDR));

  // R3
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (phase_q == PH_HDR && cnt_q == '0 && !oe_q));

  // R7
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (phase_q == PH_DATA && cnt_q == '0 && rd_q));
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int                    DEV_W       = 3,
  parameter int                    REG_W       = 5,
  parameter int                    DATA_W      = 16,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [(2**DEV_W)-1:0] DEV_MASK    = 'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n_i,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe_o,
  output logic [DEV_W-1:0]  reg_dev_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic [2:0] pins_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // bit 2: select (idles high), bit 1: bus clock, bit 0: data
  tws_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({bus_sel_n_i, bus_clk_i, bus_dat_i}),
    .q_o   (pins_s)
  );

  tws_link #(
    .DEV_W    (DEV_W),
    .REG_W    (REG_W),
    .DATA_W   (DATA_W),
    .DEV_MASK (DEV_MASK)
  ) u_link (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sel_s       (pins_s[2]),
    .bclk_s      (pins_s[1]),
    .dat_s       (pins_s[0]),
    .reg_rdata_i (reg_rdata_i),
    .reg_dev_o   (reg_dev_o),
    .reg_addr_o  (reg_addr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .dat_o       (bus_dat_o),
    .dat_oe_o    (bus_dat_oe_o)
  );
endmodule

// File: tb/tw_reg_slave_tb_top.sv
module tw_reg_slave_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 6;
  localparam logic [7:0] MASK       = 8'h06;
  localparam int         NVEC       = 12;
  // {device[2:0], read, register[4:0], data[15:0]}; data is the expected value on reads
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 5'd3,  16'hA5C3},
    {3'd2, 1'b0, 5'd3,  16'h1234},
    {3'd1, 1'b1, 5'd3,  16'hA5C3},
    {3'd2, 1'b1, 5'd3,  16'h1234},
    {3'd5, 1'b0, 5'd3,  16'hFFFF},
    {3'd1, 1'b1, 5'd3,  16'hA5C3},
    {3'd5, 1'b1, 5'd3,  16'h0000},
    {3'd2, 1'b0, 5'd31, 16'h8001},
    {3'd2, 1'b1, 5'd31, 16'h8001},
    {3'd1, 1'b1, 5'd0,  16'h0000},
    {3'd1, 1'b0, 5'd16, 16'h0001},
    {3'd1, 1'b1, 5'd16, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_n = 1'b1;
  logic        bus_clk = 1'b0;
  logic        bus_dat = 1'b0;
  logic        bus_dat_o, bus_dat_oe;
  logic [2:0]  reg_dev;
  logic [4:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] mem [8][32];
  int          checks = 0;
  int          fails = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [2:0]  last_dev;
  logic [4:0]  last_reg;
  logic [15:0] last_data;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_slave dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel_n_i  (bus_sel_n),
    .bus_clk_i    (bus_clk),
    .bus_dat_i    (bus_dat),
    .bus_dat_o    (bus_dat_o),
    .bus_dat_oe_o (bus_dat_oe),
    .reg_dev_o    (reg_dev),
    .reg_addr_o   (reg_addr),
    .reg_rd_o     (reg_rd),
    .reg_wr_o     (reg_wr),
    .reg_wdata_o  (reg_wdata),
    .reg_rdata_i  (reg_rdata)
  );

  // register file model on the parallel side
  assign reg_rdata = mem[reg_dev][reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_dev][reg_addr] <= reg_wdata;

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (reg_wr) begin
      wr_cnt    <= wr_cnt + 1;
      last_dev  <= reg_dev;
      last_reg  <= reg_addr;
      last_data <= reg_wdata;
    end
    if (reg_rd && reg_wr) begin
      fails <= fails + 1;
      $display("FAIL R10 both strobes high act=1 exp=0");
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_edge(input logic b, output logic r, output logic oe);
    bus_dat = b;
    wait_cyc(HALF);
    bus_clk = 1'b1;
    wait_cyc(HALF);
    r  = bus_dat_o;
    oe = bus_dat_oe;
    bus_clk = 1'b0;
  endtask

  task automatic frame_bits(input logic [2:0] dv, input logic rw, input logic [4:0] rg,
                            input logic [15:0] wd, output logic [15:0] rd, output int oe_hi);
    logic [8:0] hdr;
    logic       r, oe;
    hdr   = {dv, rw, rg};
    rd    = '0;
    oe_hi = 0;
    for (int i = 8; i >= 0; i--) bit_edge(hdr[i], r, oe);
    for (int i = 15; i >= 0; i--) begin
      bit_edge(rw ? 1'b0 : wd[i], r, oe);
      rd[i] = r;
      if (oe) oe_hi++;
    end
    bus_dat = 1'b0;
  endtask

  task automatic select(input logic lvl);
    bus_sel_n = lvl;
    wait_cyc(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]  dv;
    logic        rw;
    logic [4:0]  rg;
    logic [15:0] dat, rdv;
    int          oe_hi, rd0, wr0;
    bit          hit;
    logic        r, oe;

    for (int d = 0; d < 8; d++)
      for (int a = 0; a < 32; a++) mem[d][a] = '0;

    wait_cyc(3);
    // R1: outputs quiet while reset is held
    chk(bus_dat_oe == 1'b0, "R1 oe in reset", 32'(bus_dat_oe), 0);
    chk(!reg_rd && !reg_wr, "R1 strobes in reset", {reg_rd, reg_wr}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(bus_dat_oe == 1'b0 && !reg_rd && !reg_wr, "R1 after reset",
        {bus_dat_oe, reg_rd, reg_wr}, 0);

    // vector table: R4 R5 R6 R8 across matched and unmatched devices
    for (int v = 0; v < NVEC; v++) begin
      {dv, rw, rg, dat} = VEC[v];
      hit = MASK[dv];
      rd0 = rd_cnt;
      wr0 = wr_cnt;
      select(1'b0);
      frame_bits(dv, rw, rg, dat, rdv, oe_hi);
      select(1'b1);
      if (rw) begin
        chk(rd_cnt - rd0 == int'(hit), "R6 read strobe count", rd_cnt - rd0, int'(hit));
        chk(wr_cnt == wr0, "R8 no write on read", wr_cnt - wr0, 0);
        if (hit) begin
          chk(rdv == dat, "R6 read data msb first", rdv, dat);
          chk(oe_hi == 16, "R7 oe over data phase", oe_hi, 16);
        end else begin
          chk(oe_hi == 0, "R8 oe off for unmatched", oe_hi, 0);
        end
      end else begin
        chk(wr_cnt - wr0 == int'(hit), "R5 write strobe count", wr_cnt - wr0, int'(hit));
        chk(rd_cnt == rd0, "R8 no read on write", rd_cnt - rd0, 0);
        if (hit)
          chk(last_dev == dv && last_reg == rg && last_data == dat, "R4 R5 write fields",
              {last_dev, last_reg, last_data}, {dv, rg, dat});
      end
      chk(bus_dat_oe == 1'b0, "R3 oe off after select high", 32'(bus_dat_oe), 0);
    end

    // R2: clock edges while deselected change nothing
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    for (int i = 0; i < 25; i++) bit_edge(1'b1, r, oe);
    wait_cyc(HALF);
    chk(rd_cnt == rd0 && wr_cnt == wr0 && !bus_dat_oe, "R2 ignored while deselected",
        {rd_cnt - rd0, wr_cnt - wr0}, 0);
    select(1'b0);
    frame_bits(3'd1, 1'b0, 5'd5, 16'hBEEF, rdv, oe_hi);
    select(1'b1);
    chk(wr_cnt - wr0 == 1 && last_reg == 5'd5 && last_data == 16'hBEEF, "R2 frame after idle clocks",
        {last_reg, last_data}, {5'd5, 16'hBEEF});

    // R3: partial header then select high; the next frame must align
    select(1'b0);
    for (int i = 0; i < 4; i++) bit_edge(1'b1, r, oe);
    select(1'b1);
    select(1'b0);
    wr0 = wr_cnt;
    frame_bits(3'd2, 1'b0, 5'd9, 16'h5A5A, rdv, oe_hi);
    select(1'b1);
    chk(wr_cnt - wr0 == 1 && last_dev == 3'd2 && last_reg == 5'd9 && last_data == 16'h5A5A,
        "R3 header abort", {last_dev, last_reg, last_data}, {3'd2, 5'd9, 16'h5A5A});

    // R3: abort in the data phase gives no write
    wr0 = wr_cnt;
    select(1'b0);
    begin
      logic [8:0] hdr;
      hdr = {3'd1, 1'b0, 5'd9};
      for (int i = 8; i >= 0; i--) bit_edge(hdr[i], r, oe);
      for (int i = 0; i < 8; i++) bit_edge(1'b1, r, oe);
    end
    select(1'b1);
    chk(wr_cnt == wr0, "R3 data abort no write", wr_cnt - wr0, 0);
    select(1'b0);
    frame_bits(3'd1, 1'b1, 5'd9, 16'h0, rdv, oe_hi);
    select(1'b1);
    chk(rdv == 16'h0000, "R3 aborted register untouched", rdv, 0);

    // R9: back-to-back frames under one select, then R7 hold and release
    select(1'b0);
    frame_bits(3'd1, 1'b0, 5'd12, 16'hC33C, rdv, oe_hi);
    frame_bits(3'd1, 1'b1, 5'd12, 16'h0, rdv, oe_hi);
    chk(rdv == 16'hC33C && oe_hi == 16, "R9 back-to-back read", rdv, 16'hC33C);
    chk(bus_dat_oe == 1'b1, "R7 oe held after last bit", 32'(bus_dat_oe), 1);
    select(1'b1);
    chk(bus_dat_oe == 1'b0, "R7 oe released by select", 32'(bus_dat_oe), 0);

    // R7: next header edge also releases the driver
    select(1'b0);
    frame_bits(3'd2, 1'b1, 5'd31, 16'h0, rdv, oe_hi);
    bit_edge(1'b0, r, oe);
    chk(oe == 1'b0, "R7 oe released by header edge", 32'(oe), 0);
    select(1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule